// File: doc/BRIEF.md
# Multi-Format Serial Audio Receiver

This block is the slave-side input port of a stereo playback path. An external master supplies a bit clock, a word-select line and a serial data line. The block oversamples these three lines with its own system clock and finds the active bit-clock edge. It then rebuilds each channel word and presents a left/right sample pair on parallel outputs, with a one-cycle valid strobe once per stereo frame. The block never drives a clock.

A 3-bit format code chooses between two alignments. In the I2S-style alignment the word starts one bit after the word-select change. In the LSB-justified alignment the word ends on the last bit before the word-select change. The code also sets the sample width (16 or 18 bits) and the frame length (32, 48 or 64 bit clocks per stereo frame). A separate input chooses which bit-clock edge samples the lines. The frame length is never counted. It follows from the word-select line, so one datapath covers all three ratios.

Top module: `saud_rx`

## Requirements
- R1: While reset is asserted, and after it, both sample outputs read zero and the valid strobe is low until a complete frame has been received.
- R2: Format codes 000, 001, 010 and 011 are LSB-justified, with 16 bits/32 clocks, 16 bits/64 clocks, 16 bits/48 clocks and 18 bits/64 clocks per frame. Word select high marks the left channel, and a word's LSB is the last bit sampled before word select changes.
- R3: With the edge-select input at 0, the bit clock's rising edge samples word select and data. With it at 1, the falling edge does.
- R4: Format codes 100, 101, 110 and 111 are I2S-style at the same four width/ratio pairs as R2. Word select low marks the left channel, and a word's MSB is the bit sampled one bit clock after word select changes.
- R5: Data bits outside the active sample width have no effect on the delivered samples. This covers bits before the word in LSB-justified slots and bits after it in I2S slots.
- R6: The left channel is the first word of a frame. After reset, the block ignores the slot in progress and delivers its first pair only once a complete left slot and then a complete right slot have been received.
- R7: Samples are MSB-first two's complement. An 18-bit sample fills the 18-bit output. A 16-bit sample sits in bits 17..2 with bits 1..0 zero.
- R8: The valid strobe is high for exactly one system-clock cycle per frame. Both sample outputs change only in a cycle where the strobe is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the serial lines |
| rst_n | input | 1 | Asynchronous active-low reset |
| bck_i | input | 1 | Serial bit clock from the master |
| ws_i | input | 1 | Word-select line from the master |
| sd_i | input | 1 | Serial data line |
| mode_i | input | 3 | Format code (alignment, width, frame ratio) |
| edge_sel_i | input | 1 | 0: rising bit-clock edge samples, 1: falling edge |
| left_o | output | OUT_W | Left sample, left-aligned |
| right_o | output | OUT_W | Right sample, left-aligned |
| valid_o | output | 1 | One-cycle strobe when a new pair is presented |

## Verification
The bench builds the block with its default parameters: a two-stage input synchroniser, an 18-bit output and a 6-bit slot counter. It drives a bit clock of eight system clocks per bit. At that rate all three frame ratios and both edge selections can be exercised in a short run. The synchroniser and edge detector see each bit-clock level for several cycles, so the frame-pairing logic is exercised under its normal timing. The 16-bit modes with 64- and 48-clock frames leave filler bits in every slot. The bench sets those bits to ones, which shows whether any of them leak into the delivered words.

// File: rtl/saud_rx_pkg.sv
package saud_rx_pkg;

   localparam int LONG_W  = 18;
   localparam int SHORT_W = 16;

   typedef struct packed {
      logic i2s;   // 1: word starts one bit after word-select change
      logic wide;  // 1: 18-bit sample, 0: 16-bit sample
   } fmt_t;

   // Format code: bit 2 picks alignment, code 11 in bits 1..0 picks 18 bits.
   function automatic fmt_t decode_fmt(input logic [2:0] code);
      fmt_t f;
      f.i2s  = code[2];
      f.wide = (code[1:0] == 2'b11);
      return f;
   endfunction

endpackage

// File: rtl/saud_rx_sync.sv
module saud_rx_sync #(
   parameter int W      = 1,
   parameter int STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d_i,
   output logic [W-1:0] q_o
);

   if (STAGES < 2) begin : g_bad_stages
      $error("saud_rx_sync: STAGES must be at least 2");
   end

   for (genvar b = 0; b < W; b++) begin : g_bit
      logic [STAGES-1:0] chain_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) chain_q <= '0;
         else        chain_q <= {chain_q[STAGES-2:0], d_i[b]};
      end
      assign q_o[b] = chain_q[STAGES-1];
   end

endmodule

// File: rtl/saud_rx_edge.sv
module saud_rx_edge (
   input  logic clk,
   input  logic rst_n,
   input  logic bck_s_i,
   input  logic edge_sel_i,
   output logic act_o
);

   logic bck_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) bck_q <= 1'b0;
      else        bck_q <= bck_s_i;
   end

   logic rise, fall;
   assign rise  =  bck_s_i & ~bck_q;
   assign fall  = ~bck_s_i &  bck_q;
   assign act_o = edge_sel_i ? fall : rise;

   // R3: an active edge lasts exactly one system cycle
   a_r3_edge_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      act_o |=> !act_o);

endmodule

// File: rtl/saud_rx_slot.sv
module saud_rx_slot
   import saud_rx_pkg::*;
#(
   parameter int OUT_W = 18,
   parameter int CNT_W = 6
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             act_i,
   input  logic             ws_i,
   input  logic             sd_i,
   input  logic             i2s_i,
   input  logic             wide_i,
   output logic             done_o,
   output logic             done_left_o,
   output logic [OUT_W-1:0] word_o
);

   localparam logic [CNT_W-1:0] LIM_LONG  = CNT_W'(LONG_W);
   localparam logic [CNT_W-1:0] LIM_SHORT = CNT_W'(SHORT_W);
   localparam int               PAD_LONG  = OUT_W - LONG_W;
   localparam int               PAD_SHORT = OUT_W - SHORT_W;

   logic              ws_prev_q;
   logic              tag_q;
   logic [1:0]        prime_q;
   logic              synced_q;
   logic [LONG_W-1:0] sh_q;
   logic [CNT_W-1:0]  cnt_q;
   logic              done_q;
   logic              dleft_q;
   logic [OUT_W-1:0]  word_q;

   // Channel tag of the bit sampled now (1 = left).
   logic tag_now;
   assign tag_now = i2s_i ? ~ws_prev_q : ws_i;

   logic boundary;
   assign boundary = prime_q[1] & (tag_now != tag_q);

   logic [CNT_W-1:0] limit;
   assign limit = wide_i ? LIM_LONG : LIM_SHORT;

   logic may_shift;
   assign may_shift = !i2s_i || (cnt_q < limit);

   logic [OUT_W-1:0] word_fmt;
   always_comb begin
      if (wide_i) word_fmt = OUT_W'(sh_q) << PAD_LONG;
      else        word_fmt = OUT_W'(sh_q[SHORT_W-1:0]) << PAD_SHORT;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ws_prev_q <= 1'b0;
         tag_q     <= 1'b0;
         prime_q   <= '0;
         synced_q  <= 1'b0;
         sh_q      <= '0;
         cnt_q     <= '0;
         done_q    <= 1'b0;
         dleft_q   <= 1'b0;
         word_q    <= '0;
      end else begin
         done_q <= 1'b0;
         if (act_i) begin
            ws_prev_q <= ws_i;
            tag_q     <= tag_now;
            prime_q   <= {prime_q[0], 1'b1};
            if (boundary) begin
               synced_q <= 1'b1;
               if (synced_q) begin
                  done_q  <= 1'b1;
                  dleft_q <= tag_q;
                  word_q  <= word_fmt;
               end
               sh_q  <= {{(LONG_W-1){1'b0}}, sd_i};
               cnt_q <= CNT_W'(1);
            end else begin
               if (may_shift) sh_q <= {sh_q[LONG_W-2:0], sd_i};
               if (!(&cnt_q)) cnt_q <= cnt_q + 1'b1;
            end
         end
      end
   end

   assign done_o      = done_q;
   assign done_left_o = dleft_q;
   assign word_o      = word_q;

   // R3: a word completes only on an active bit-clock edge
   a_r3_done_on_edge: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> $past(act_i));

endmodule

// File: rtl/saud_rx.sv
module saud_rx
   import saud_rx_pkg::*;
#(
   parameter int SYNC_STAGES = 2,
   parameter int OUT_W       = 18,
   parameter int CNT_W       = 6
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             bck_i,
   input  logic             ws_i,
   input  logic             sd_i,
   input  logic [2:0]       mode_i,
   input  logic             edge_sel_i,
   output logic [OUT_W-1:0] left_o,
   output logic [OUT_W-1:0] right_o,
   output logic             valid_o
);

   if (OUT_W < LONG_W) begin : g_bad_out
      $error("saud_rx: OUT_W must hold an 18-bit sample");
   end
   if ((1 << CNT_W) <= 32) begin : g_bad_cnt
      $error("saud_rx: CNT_W too small for a 32-bit slot");
   end

   fmt_t fmt;
   assign fmt = decode_fmt(mode_i);

   logic [2:0] raw_lines, sync_lines;
   assign raw_lines = {bck_i, ws_i, sd_i};

   saud_rx_sync #(.W(3), .STAGES(SYNC_STAGES)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d_i   (raw_lines),
      .q_o   (sync_lines)
   );

   logic act;
   saud_rx_edge u_edge (
      .clk        (clk),
      .rst_n      (rst_n),
      .bck_s_i    (sync_lines[2]),
      .edge_sel_i (edge_sel_i),
      .act_o      (act)
   );

   logic             done, done_left;
   logic [OUT_W-1:0] word;
   saud_rx_slot #(.OUT_W(OUT_W), .CNT_W(CNT_W)) u_slot (
      .clk         (clk),
      .rst_n       (rst_n),
      .act_i       (act),
      .ws_i        (sync_lines[1]),
      .sd_i        (sync_lines[0]),
      .i2s_i       (fmt.i2s),
      .wide_i      (fmt.wide),
      .done_o      (done),
      .done_left_o (done_left),
      .word_o      (word)
   );

   // Frame pairing: hold the left word until its right partner completes.
   logic [OUT_W-1:0] left_hold_q;
   logic             have_left_q;
   logic [OUT_W-1:0] left_q, right_q;
   logic             valid_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         left_hold_q <= '0;
         have_left_q <= 1'b0;
         left_q      <= '0;
         right_q     <= '0;
         valid_q     <= 1'b0;
      end else begin
         valid_q <= 1'b0;
         if (done) begin
            if (done_left) begin
               left_hold_q <= word;
               have_left_q <= 1'b1;
            end else begin
               have_left_q <= 1'b0;
               if (have_left_q) begin
                  left_q  <= left_hold_q;
                  right_q <= word;
                  valid_q <= 1'b1;
               end
            end
         end
      end
   end

   assign left_o  = left_q;
   assign right_o = right_q;
   assign valid_o = valid_q;

   // R8: strobe is a single cycle
   a_r8_valid_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      valid_o |=> !valid_o);

   // R8: samples move only together with the strobe
   a_r8_out_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (!$stable(left_o) || !$stable(right_o)) |-> valid_o);

endmodule

// File: tb/saud_rx_tb.sv
module saud_rx_tb;

   localparam int CLK_P     = 10;
   localparam int HALF_CLKS = 4;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bck = 1'b0, ws = 1'b0, sd = 1'b0;
   logic [2:0]  mode = 3'b000;
   logic        edge_sel = 1'b0;
   logic [17:0] left_o, right_o;
   logic        valid_o;

   int checks = 0, errors = 0;
   int vcount = 0, pulse_err = 0, hold_err = 0;
   logic [17:0] last_l = '0, last_r = '0, prev_l = '0, prev_r = '0;
   logic [17:0] samp_l = '0, samp_r = '0;
   logic        prev_valid = 1'b0;

   always #(CLK_P/2) clk = ~clk;

   saud_rx u_dut (
      .clk(clk), .rst_n(rst_n), .bck_i(bck), .ws_i(ws), .sd_i(sd),
      .mode_i(mode), .edge_sel_i(edge_sel),
      .left_o(left_o), .right_o(right_o), .valid_o(valid_o)
   );

   always @(negedge clk) begin
      if (rst_n) begin
         if (valid_o) begin
            if (prev_valid) pulse_err++;
            prev_l = last_l; prev_r = last_r;
            last_l = left_o; last_r = right_o;
            vcount++;
         end else if (left_o !== samp_l || right_o !== samp_r) begin
            hold_err++;
         end
      end
      prev_valid = valid_o;
      samp_l = left_o;
      samp_r = right_o;
   end

   task automatic chk(input string req, input logic [17:0] act, input logic [17:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic bit_out(input logic w, input logic d);
      @(negedge clk);
      bck = edge_sel; ws = w; sd = d;
      repeat (HALF_CLKS) @(negedge clk);
      bck = ~edge_sel;
      repeat (HALF_CLKS - 1) @(negedge clk);
   endtask

   function automatic int slot_len(input logic [2:0] m);
      case (m[1:0])
         2'b00:   return 16;
         2'b10:   return 24;
         default: return 32;
      endcase
   endfunction

   // Send nbits of one slot carrying word (low W bits used), fillers are ones.
   task automatic send_slot(input logic is_left, input logic [17:0] word, input int nbits);
      int s   = slot_len(mode);
      int w   = (mode[1:0] == 2'b11) ? 18 : 16;
      for (int k = 0; k < nbits; k++) begin
         logic wv, dv;
         if (mode[2]) begin
            wv = is_left ? 1'b0 : 1'b1;
            if (k == s - 1) wv = ~wv;
            dv = (k < w) ? word[w-1-k] : 1'b1;
         end else begin
            wv = is_left;
            dv = (k >= s - w) ? word[s-1-k] : 1'b1;
         end
         bit_out(wv, dv);
      end
   endtask

   function automatic logic [17:0] expect_word(input logic [17:0] v, input logic wide);
      return wide ? v : {v[15:0], 2'b00};
   endfunction

   function automatic logic [17:0] lval(input int f, input logic [2:0] m);
      return 18'h2A5C3 ^ 18'(f * 18'h01357) ^ {m, 15'h0};
   endfunction

   function automatic logic [17:0] rval(input int f);
      return 18'h15A3C ^ 18'(f * 18'h00BD1);
   endfunction

   task automatic do_reset();
      @(posedge clk); rst_n = 1'b0;
      repeat (3) @(posedge clk);
      @(negedge clk);
      chk("R1 left at reset",  left_o, '0);
      chk("R1 right at reset", right_o, '0);
      chk("R1 valid at reset", {17'h0, valid_o}, '0);
      @(posedge clk); rst_n = 1'b1;
   endtask

   task automatic run_fmt(input logic [2:0] m, input logic es);
      logic  wide = (m[1:0] == 2'b11);
      int    s    = slot_len(m);
      string req;
      mode = m; edge_sel = es;
      req = $sformatf("%s%s%s%s mode=%b edge=%b",
                      m[2] ? "R4" : "R2", es ? " R3" : " R3rise",
                      wide ? "" : " R7", (s > (wide ? 18 : 16)) ? " R5" : "", m, es);
      for (int f = 1; f <= 3; f++) begin
         send_slot(1'b1, lval(f, m), s);
         send_slot(1'b0, rval(f), s);
      end
      send_slot(1'b1, 18'h3FFFF, 3);
      repeat (20) @(negedge clk);
      chk({req, " left frame3"},  last_l, expect_word(lval(3, m), wide));
      chk({req, " right frame3"}, last_r, expect_word(rval(3), wide));
      chk({req, " left frame2"},  prev_l, expect_word(lval(2, m), wide));
      chk({req, " right frame2"}, prev_r, expect_word(rval(2), wide));
   endtask

   task automatic run_resync();
      int v0;
      mode = 3'b001; edge_sel = 1'b0;
      do_reset();
      v0 = vcount;
      send_slot(1'b0, 18'h3FFFF, 32);
      send_slot(1'b1, 18'h0BEEF, 32);
      send_slot(1'b0, 18'h0CAFE, 32);
      send_slot(1'b1, 18'h3FFFF, 3);
      repeat (20) @(negedge clk);
      chk("R6 one pair after reset", 18'(vcount - v0), 18'd1);
      chk("R6 left after resync",  last_l, {16'hBEEF, 2'b00});
      chk("R6 right after resync", last_r, {16'hCAFE, 2'b00});
   endtask

   initial begin
      fork
         begin
            do_reset();
            run_fmt(3'b000, 1'b0);
            run_fmt(3'b001, 1'b1);
            run_fmt(3'b010, 1'b0);
            run_fmt(3'b011, 1'b1);
            run_fmt(3'b100, 1'b1);
            run_fmt(3'b101, 1'b0);
            run_fmt(3'b110, 1'b1);
            run_fmt(3'b111, 1'b0);
            run_resync();
            chk("R8 strobe width", 18'(pulse_err), 18'd0);
            chk("R8 outputs hold", 18'(hold_err), 18'd0);
         end
         begin
            repeat (150000) @(posedge clk);
            checks++; errors++;
            $display("FAIL watchdog actual=timeout expected=done");
         end
      join_any
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule